// File: doc/BRIEF.md
# Request-Grant Receiver Collision Controller

This block sits in one node of a slotted ring and guards against a single destination being swamped by several senders on different channels at once. It watches the control field that rides in every slot header, counts how many slots in a row the node has had traffic queued without managing to send any, and once that wait crosses a tolerance it stamps a request naming the congested destination into the next empty control field. The request travels around the ring and every node that holds traffic for that destination switches from free access into a limited mode. In limited mode the node may send only a fixed quota of packets to the congested destination.

The requesting node (the tail) turns its returning request into a satisfied token. A limited node that still has quota left holds the token, and passes it on once it has finished with the congested destination. When the token comes back to the tail, the tail replaces it with a grant. Every limited node that sees the grant returns to free access, and the tail removes the grant when it has gone all the way round. The transmit scheduler reads a per-destination permission mask that blocks only the congested destination, and only while the node is limited and done with its quota.

The control field passes through combinationally in the slot in which it arrives. All state changes at the clock edge that ends a valid slot.

Top module: `rgc_ctrl`

## Requirements
- R1: After reset the mode is free access (code 00), every bit of the permission mask is 1, and the control field is passed through unchanged.
- R2: In free access, each valid slot in which some queue is non-empty and no packet is sent advances the wait counter by one, saturating at the tolerance `QD`. A send, an empty queue set, or leaving free access clears it.
- R3: In free access with no grant outstanding, the first valid slot that satisfies all of the following raises a request: the wait counter already equals `QD`, the incoming message code is none (00), and some queue is non-empty. The request writes code 01 and the lowest-indexed non-empty destination, and the mode becomes tail (01).
- R4: When no rule rewrites it, the outgoing control field equals the incoming one in the same cycle. A slot with `slot_valid` low changes no state.
- R5: A free node with no grant outstanding that receives a request (01) for a destination it has queued traffic for forwards it unchanged and enters limited-active mode (10) for that destination. A request for an unqueued destination leaves the node in free access.
- R6: In limited-active mode, each send to the congested destination counts against `QUOTA`. At the end of the slot in which the count reaches `QUOTA`, or in which that destination's queue is empty, the mode becomes limited-inactive (11). In limited-inactive mode only the congested destination's mask bit is 0.
- R7: A limited-active node removes an arriving satisfied token (10) for its congested destination, so the outgoing code is 00. After it turns limited-inactive, it writes that token into the first valid slot whose code is 00. A limited-inactive node with no token held forwards such tokens unchanged.
- R8: A tail node replaces an arriving request for its destination with a satisfied token. It replaces an arriving satisfied token for its destination with a grant (11), then returns to free access with a grant outstanding.
- R9: A grant for its congested destination returns a limited node to free access and is forwarded. A node with a grant outstanding removes the grant for that destination and clears the outstanding flag. While the flag is set, it raises no request and forwards requests without entering limited mode.
- R10: Tail and limited nodes forward messages that name other destinations unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A slot header is present this cycle |
| ca_msg_in | input | 2 | Incoming control message code (00 none, 01 request, 10 satisfied, 11 grant) |
| ca_dst_in | input | AW | Destination named by the incoming control message |
| tx_done | input | 1 | The node sent a packet in this slot |
| tx_dst | input | AW | Destination of the packet sent |
| q_nonempty | input | 2**AW | Per-destination queue holds packets |
| ca_msg_out | output | 2 | Outgoing control message code |
| ca_dst_out | output | AW | Outgoing control message destination |
| mode | output | 2 | 00 free, 01 tail, 10 limited-active, 11 limited-inactive |
| dest_allow | output | 2**AW | Per-destination send permission for the scheduler |

## Verification
A wrong wait count shows as a request written one or more slots early or late. That is seen at the control field output in the slot it should have appeared, or would have appeared. A wrong quota count or lost token state shows at the `mode` port at the very next clock edge after the decisive send, and in the permission mask in that same cycle. A slip in the tail or grant-outstanding bookkeeping shows within one slot as a message that is rewritten or removed when it should have been forwarded. The bench therefore compares the control field, mode and mask with a behavioural model in every cycle, so any divergence is reported in the slot where it first appears.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

  typedef enum logic [1:0] {
    MSG_NONE = 2'b00,
    MSG_REQ  = 2'b01,
    MSG_SAT  = 2'b10,
    MSG_GNT  = 2'b11
  } rgc_msg_e;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_TAIL   = 2'b01,
    MODE_LACT   = 2'b10,
    MODE_LINACT = 2'b11
  } rgc_mode_e;

endpackage

// File: rtl/rgc_delay_ctr.sv
module rgc_delay_ctr #(
  parameter int QD = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot_en,
  input  logic                        clear,
  output logic [$clog2(QD+1)-1:0]     count,
  output logic                        tripped
);
  localparam int CW = $clog2(QD + 1);
  localparam logic [CW-1:0] LIM = CW'(QD);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v < LIM) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (slot_en) begin
      if (clear) cnt_q <= '0;
      else       cnt_q <= sat_inc(cnt_q);
    end
  end

  assign count   = cnt_q;
  assign tripped = (cnt_q >= LIM);

  p_ctr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  p_ctr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !clear && !tripped) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_ctr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && clear) |=> (cnt_q == '0));

endmodule

// File: rtl/rgc_quota_ctr.sv
module rgc_quota_ctr #(
  parameter int QUOTA = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          hit,
  output logic [$clog2(QUOTA+1)-1:0]    used,
  output logic                          spent
);
  localparam int UW = $clog2(QUOTA + 1);
  localparam logic [UW-1:0] LIM = UW'(QUOTA);

  logic [UW-1:0] used_q;

  function automatic logic reaches(input logic [UW-1:0] v, input logic h);
    logic [UW:0] sum;
    sum = {1'b0, v} + {{UW{1'b0}}, h};
    return sum >= {1'b0, LIM};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (load) begin
      used_q <= '0;
    end else if (hit && used_q < LIM) begin
      used_q <= used_q + 1'b1;
    end
  end

  assign used  = used_q;
  assign spent = reaches(used_q, hit);

  p_quota_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= LIM);

  p_quota_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (used_q == '0));

endmodule

// File: rtl/rgc_dest_pick.sv
module rgc_dest_pick #(
  parameter int AW = 4
) (
  input  logic [(1<<AW)-1:0] q_nonempty,
  output logic [AW-1:0]      pick,
  output logic               any
);
  localparam int NDST = 1 << AW;

  function automatic logic [AW-1:0] lowest_set(input logic [NDST-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = NDST - 1; i >= 0; i--) begin
      if (v[i]) r = AW'(i);
    end
    return r;
  endfunction

  assign pick = lowest_set(q_nonempty);
  assign any  = |q_nonempty;

endmodule

// File: rtl/rgc_ctrl.sv
module rgc_ctrl
  import rgc_pkg::*;
#(
  parameter int AW    = 4,
  parameter int QD    = 8,
  parameter int QUOTA = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_valid,
  input  logic [1:0]           ca_msg_in,
  input  logic [AW-1:0]        ca_dst_in,
  input  logic                 tx_done,
  input  logic [AW-1:0]        tx_dst,
  input  logic [(1<<AW)-1:0]   q_nonempty,
  output logic [1:0]           ca_msg_out,
  output logic [AW-1:0]        ca_dst_out,
  output logic [1:0]           mode,
  output logic [(1<<AW)-1:0]   dest_allow
);
  localparam int NDST = 1 << AW;
  localparam int CW   = $clog2(QD + 1);
  localparam int UW   = $clog2(QUOTA + 1);

  // registered state
  rgc_mode_e     mode_q, nxt_mode;
  logic [AW-1:0] heavy_q, nxt_heavy;
  logic          held_q, nxt_held;
  logic          pend_q, nxt_pend;
  logic [AW-1:0] pend_dst_q, nxt_pend_dst;

  // named internal events
  rgc_msg_e      msg_in, msg_out;
  logic [AW-1:0] dst_out;
  logic          hit_heavy;
  logic          queued_in;
  logic          heavy_queued;
  logic          enter_lim;
  logic          raise_req;
  logic          quota_hit;
  logic          quota_spent;
  logic [UW-1:0] quota_used;
  logic          dly_tripped;
  logic [CW-1:0] dly_count;
  logic          dly_clear;
  logic [AW-1:0] pick_dst;
  logic          pick_any;

  assign msg_in       = rgc_msg_e'(ca_msg_in);
  assign hit_heavy    = (ca_dst_in == heavy_q);
  assign queued_in    = q_nonempty[ca_dst_in];
  assign heavy_queued = q_nonempty[heavy_q];

  rgc_dest_pick #(.AW(AW)) u_pick (
    .q_nonempty (q_nonempty),
    .pick       (pick_dst),
    .any        (pick_any)
  );

  rgc_delay_ctr #(.QD(QD)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_en (slot_valid),
    .clear   (dly_clear),
    .count   (dly_count),
    .tripped (dly_tripped)
  );

  assign quota_hit = slot_valid && (mode_q == MODE_LACT) && tx_done && (tx_dst == heavy_q);

  rgc_quota_ctr #(.QUOTA(QUOTA)) u_quota (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (enter_lim),
    .hit   (quota_hit),
    .used  (quota_used),
    .spent (quota_spent)
  );

  // slot rewrite and next-state decision
  always_comb begin
    msg_out      = msg_in;
    dst_out      = ca_dst_in;
    nxt_mode     = mode_q;
    nxt_heavy    = heavy_q;
    nxt_held     = held_q;
    nxt_pend     = pend_q;
    nxt_pend_dst = pend_dst_q;
    enter_lim    = 1'b0;
    raise_req    = 1'b0;
    if (slot_valid) begin
      unique case (mode_q)
        MODE_FREE: begin
          if (msg_in == MSG_REQ && !pend_q && queued_in) begin
            nxt_mode  = MODE_LACT;
            nxt_heavy = ca_dst_in;
            nxt_held  = 1'b0;
            enter_lim = 1'b1;
          end else if (msg_in == MSG_GNT && pend_q && ca_dst_in == pend_dst_q) begin
            msg_out  = MSG_NONE;
            nxt_pend = 1'b0;
          end else if (msg_in == MSG_NONE && dly_tripped && pick_any && !pend_q) begin
            msg_out   = MSG_REQ;
            dst_out   = pick_dst;
            nxt_mode  = MODE_TAIL;
            nxt_heavy = pick_dst;
            raise_req = 1'b1;
          end
        end
        MODE_TAIL: begin
          if (hit_heavy && msg_in == MSG_REQ) begin
            msg_out = MSG_SAT;
          end else if (hit_heavy && msg_in == MSG_SAT) begin
            msg_out      = MSG_GNT;
            nxt_mode     = MODE_FREE;
            nxt_pend     = 1'b1;
            nxt_pend_dst = heavy_q;
          end
        end
        MODE_LACT: begin
          if (hit_heavy && msg_in == MSG_GNT) begin
            nxt_mode = MODE_FREE;
            nxt_held = 1'b0;
          end else begin
            if (hit_heavy && msg_in == MSG_SAT) begin
              msg_out  = MSG_NONE;
              nxt_held = 1'b1;
            end
            if (quota_spent || !heavy_queued) nxt_mode = MODE_LINACT;
          end
        end
        MODE_LINACT: begin
          if (hit_heavy && msg_in == MSG_GNT) begin
            nxt_mode = MODE_FREE;
            nxt_held = 1'b0;
          end else if (held_q && msg_in == MSG_NONE) begin
            msg_out  = MSG_SAT;
            dst_out  = heavy_q;
            nxt_held = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign dly_clear = (mode_q != MODE_FREE) || (nxt_mode != MODE_FREE) ||
                     tx_done || !pick_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_FREE;
      heavy_q    <= '0;
      held_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_dst_q <= '0;
    end else begin
      mode_q     <= nxt_mode;
      heavy_q    <= nxt_heavy;
      held_q     <= nxt_held;
      pend_q     <= nxt_pend;
      pend_dst_q <= nxt_pend_dst;
    end
  end

  // permission mask: one bit per destination
  for (genvar d = 0; d < NDST; d++) begin : g_allow
    assign dest_allow[d] = !((mode_q == MODE_LINACT) && (heavy_q == AW'(d)));
  end

  assign ca_msg_out = msg_out;
  assign ca_dst_out = dst_out;
  assign mode       = mode_q;

  // guards
  p_raise_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && mode_q == MODE_FREE && msg_in == MSG_NONE && ca_msg_out == MSG_REQ)
      |=> (mode_q == MODE_TAIL));

  p_raise_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_TAIL) |-> (dly_count == '0));

  p_enter_lim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_lim |=> (mode_q == MODE_LACT && quota_used == '0));

  p_inactive_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LINACT && !(slot_valid && msg_in == MSG_GNT && hit_heavy))
      |=> (mode_q == MODE_LINACT));

  p_mask_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LINACT) |-> ($countones(dest_allow) == NDST - 1));

  p_tail_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && mode_q == MODE_TAIL && msg_in == MSG_SAT && hit_heavy)
      |=> (mode_q == MODE_FREE && pend_q));

  p_grant_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && (mode_q == MODE_LACT || mode_q == MODE_LINACT) && msg_in == MSG_GNT && hit_heavy)
      |=> (mode_q == MODE_FREE));

  p_pend_no_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ca_msg_out == MSG_REQ) |-> (msg_in == MSG_REQ));

  p_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |=> $stable(mode_q));

endmodule

// File: tb/test_rgc_ctrl.sv
module test_rgc_ctrl;
  localparam int AW    = 3;
  localparam int N     = 8;
  localparam int QD    = 4;
  localparam int QUOTA = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         d_valid = 1'b0;
  logic [1:0]   d_msg = 2'b00;
  logic [AW-1:0] d_dst = '0;
  logic         d_tx = 1'b0;
  logic [AW-1:0] d_txd = '0;
  logic [N-1:0] d_q = '0;
  logic [1:0]   o_msg;
  logic [AW-1:0] o_dst;
  logic [1:0]   o_mode;
  logic [N-1:0] o_allow;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // model state
  int m_mode = 0, m_heavy = 0, m_c = 0, m_used = 0, m_held = 0, m_pend = 0, m_pend_dst = 0;

  always #5 clk = ~clk;

  rgc_ctrl #(.AW(AW), .QD(QD), .QUOTA(QUOTA)) i_rgc_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (d_valid),
    .ca_msg_in  (d_msg),
    .ca_dst_in  (d_dst),
    .tx_done    (d_tx),
    .tx_dst     (d_txd),
    .q_nonempty (d_q),
    .ca_msg_out (o_msg),
    .ca_dst_out (o_dst),
    .mode       (o_mode),
    .dest_allow (o_allow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference of one slot; commit=1 applies the state change
  task automatic model_slot(input bit commit, output int omsg, output int odst);
    int n_mode, n_heavy, n_c, n_used, n_held, n_pend, n_pend_dst;
    int imsg, idst, first;
    bit any, hit;
    imsg = int'(d_msg); idst = int'(d_dst);
    omsg = imsg; odst = idst;
    n_mode = m_mode; n_heavy = m_heavy; n_c = m_c; n_used = m_used;
    n_held = m_held; n_pend = m_pend; n_pend_dst = m_pend_dst;
    any = (d_q != 0);
    first = 0;
    for (int i = N - 1; i >= 0; i--) if (d_q[i]) first = i;
    hit = (idst == m_heavy);
    if (d_valid) begin
      if (m_mode == 0) begin
        if (imsg == 1 && m_pend == 0 && d_q[idst]) begin
          n_mode = 2; n_heavy = idst; n_used = 0; n_held = 0;
        end else if (imsg == 3 && m_pend == 1 && idst == m_pend_dst) begin
          omsg = 0; n_pend = 0;
        end else if (imsg == 0 && m_c >= QD && any && m_pend == 0) begin
          omsg = 1; odst = first; n_mode = 1; n_heavy = first;
        end
      end else if (m_mode == 1) begin
        if (hit && imsg == 1) omsg = 2;
        else if (hit && imsg == 2) begin
          omsg = 3; n_mode = 0; n_pend = 1; n_pend_dst = m_heavy;
        end
      end else if (m_mode == 2) begin
        if (hit && imsg == 3) begin
          n_mode = 0; n_held = 0;
        end else begin
          if (hit && imsg == 2) begin omsg = 0; n_held = 1; end
          if (d_tx && int'(d_txd) == m_heavy && n_used < QUOTA) n_used++;
          if (n_used >= QUOTA || !d_q[m_heavy]) n_mode = 3;
        end
      end else begin
        if (hit && imsg == 3) begin
          n_mode = 0; n_held = 0;
        end else if (m_held == 1 && imsg == 0) begin
          omsg = 2; odst = m_heavy; n_held = 0;
        end
      end
      if (m_mode != 0 || n_mode != 0 || d_tx || !any) n_c = 0;
      else if (n_c < QD) n_c++;
    end
    if (commit) begin
      m_mode = n_mode; m_heavy = n_heavy; m_c = n_c; m_used = n_used;
      m_held = n_held; m_pend = n_pend; m_pend_dst = n_pend_dst;
    end
  endtask

  task automatic step(input bit v, input int msg, input int dst, input bit tx,
                      input int txd, input logic [N-1:0] q, input string req);
    int em, ed, exp_allow;
    @(negedge clk);
    d_valid = v; d_msg = 2'(msg); d_dst = AW'(dst);
    d_tx = tx; d_txd = AW'(txd); d_q = q;
    #2;
    model_slot(0, em, ed);
    exp_allow = (m_mode == 3) ? ((~(1 << m_heavy)) & ((1 << N) - 1)) : ((1 << N) - 1);
    chk(req, "ca_msg", int'(o_msg), em);
    chk(req, "ca_dst", int'(o_dst), ed);
    chk(req, "mode", int'(o_mode), m_mode);
    chk(req, "dest_allow", int'(o_allow), exp_allow);
    @(posedge clk);
    #1;
    model_slot(1, em, ed);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog run did not finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state with a message on the input
    d_valid = 1'b1; d_msg = 2'b10; d_dst = 3'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "mode", int'(o_mode), 0);
    chk("R1", "dest_allow", int'(o_allow), 255);
    chk("R1", "ca_msg", int'(o_msg), 2);
    chk("R1", "ca_dst", int'(o_dst), 5);
    rst_n = 1'b1;

    // R2 wait counting, cleared by a send
    repeat (3) step(1, 0, 0, 0, 0, 8'h14, "R2");
    step(1, 0, 0, 1, 4, 8'h14, "R2");
    repeat (4) step(1, 0, 0, 0, 0, 8'h14, "R2");
    // R4 busy field delays the request
    step(1, 2, 5, 0, 0, 8'h14, "R4");
    // R3 request for lowest queued destination (2)
    step(1, 0, 0, 0, 0, 8'h14, "R3");
    // tail behaviour
    step(1, 1, 5, 0, 0, 8'h14, "R10");
    step(1, 1, 2, 0, 0, 8'h14, "R8");
    step(1, 2, 5, 0, 0, 8'h14, "R10");
    step(1, 2, 2, 0, 0, 8'h14, "R8");
    // grant outstanding
    step(1, 1, 2, 0, 0, 8'h14, "R9");
    repeat (6) step(1, 0, 0, 0, 0, 8'h14, "R9");
    step(1, 3, 4, 0, 0, 8'h00, "R9");
    step(1, 3, 2, 0, 0, 8'h00, "R9");
    step(1, 0, 0, 0, 0, 8'h00, "R9");

    // R4 invalid slot changes nothing
    step(0, 1, 3, 0, 0, 8'h08, "R4");
    step(0, 0, 0, 1, 3, 8'h08, "R4");

    // limited mode via quota
    step(1, 1, 6, 0, 0, 8'h08, "R5");
    step(1, 1, 3, 0, 0, 8'h08, "R5");
    step(1, 2, 3, 0, 0, 8'h08, "R7");
    step(1, 0, 0, 1, 3, 8'h08, "R6");
    step(1, 0, 0, 1, 1, 8'h08, "R6");
    step(1, 0, 0, 1, 3, 8'h08, "R6");
    step(1, 2, 1, 1, 3, 8'h08, "R10");
    step(1, 0, 0, 0, 0, 8'h09, "R7");
    step(1, 2, 3, 0, 0, 8'h09, "R7");
    step(1, 1, 3, 0, 0, 8'h09, "R10");
    step(1, 3, 3, 0, 0, 8'h00, "R9");
    step(1, 0, 0, 0, 0, 8'h00, "R9");

    // limited mode ended by an empty heavy queue
    step(1, 1, 4, 0, 0, 8'h10, "R5");
    step(1, 0, 0, 0, 0, 8'h00, "R6");
    step(1, 0, 0, 0, 0, 8'h00, "R6");
    step(1, 3, 2, 0, 0, 8'h00, "R10");
    step(1, 3, 4, 0, 0, 8'h00, "R9");
    repeat (2) step(1, 0, 0, 0, 0, 8'h00, "R4");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule